// File: doc/BRIEF.md
# Harmonic Compensation Reference Current Generator

This block computes the three phase-current references that a four-wire shunt compensator must inject to cancel load harmonics, reactive current and neutral (zero-sequence) current. For each sample strobe it takes the three load-current samples, a sine/cosine pair giving the grid angle, a charging correction and a balancing correction. All of these are captured on the same strobe, so every stage works with one consistent angle.

The load currents are mapped to a stationary alpha/beta/zero frame. A two-axis self-tuning filter tracks the fundamental of alpha and beta. The harmonic part is the raw value minus the tracked fundamental. The harmonic part forms the d-axis term and the raw current forms the q-axis term. The charging term is removed from d, and the result is rotated back. The balancing term is removed from the zero component, which is never rotated. The abc references come out of the inverse transform, clipped to a configurable limit.

The whole datapath is combinational between the sample inputs and one output register stage. Results appear one clock after the strobe.

Top module: `hc_ref_gen`

## Requirements
- R1: After reset, all three references are 0, `valid_o` is 0 and `ovf_o` is 0. The filter state is cleared.
- R2: `valid_o` is 1 exactly in the cycle after a cycle with `valid_i` = 1 and is 0 otherwise. The references change only in a cycle where `valid_o` is 1.
- R3: The forward transform uses floor rounding (arithmetic right shift by 15) with Q15 constants 10923 (1/3) and 18919 (1/sqrt3). alpha = ((2ia-ib-ic)*10923)>>>15, beta = ((ib-ic)*18919)>>>15, zero = ((ia+ib+ic)*10923)>>>15. With sin = cos = 0, all three references equal zero - bal.
- R4: The filter keeps states fa and fb with 8 fraction bits, cleared at reset, and updates them only on a strobe. fa += (KT*((alpha<<8)-fa) - WT*fb)>>>15 and fb += (KT*((beta<<8)-fb) + WT*fa)>>>15, both using the old states. Defaults are KT = 66 and WT = 1029.
- R5: With the updated states, ha = alpha - (fa>>>8) and hb = beta - (fb>>>8). sin and cos are Q1.15. d = (ha*sin - hb*cos)>>>15 and q = (alpha*cos + beta*sin)>>>15.
- R6: With e = d - chg, the rotated-back values are ra = (e*sin + q*cos)>>>15 and rb = (q*sin - e*cos)>>>15. With z = zero - bal, s = (rb*28378)>>>15 and h = ra>>>1, the outputs are a = ra + z, b = -h + s + z and c = -h - s + z.
- R7: Each reference is clamped to the range [-LIMIT, +LIMIT], with LIMIT defaulting to 30000.
- R8: `ovf_o` goes to 1 when any phase is clamped on a strobe. It then stays at 1 until reset.
- R9: Input changes while `valid_i` is 0 have no effect on the outputs or on the filter state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample strobe |
| ia_i | input | DATA_W | Load current phase a, signed |
| ib_i | input | DATA_W | Load current phase b, signed |
| ic_i | input | DATA_W | Load current phase c, signed |
| sin_i | input | SC_W | Sine of grid angle, signed Q1.15 |
| cos_i | input | SC_W | Cosine of grid angle, signed Q1.15 |
| chg_i | input | DATA_W | Charging correction, subtracted on the d axis |
| bal_i | input | DATA_W | Balancing correction, subtracted from zero sequence |
| ref_a_o | output | DATA_W | Reference current phase a |
| ref_b_o | output | DATA_W | Reference current phase b |
| ref_c_o | output | DATA_W | Reference current phase c |
| valid_o | output | 1 | References updated this cycle |
| ovf_o | output | 1 | Sticky clamp indicator |

## Verification
The assertions check the following on every cycle:
- the one-cycle strobe-to-valid relation;
- that the references hold while `valid_o` is low;
- that each reference stays inside the clamp range;
- that the overflow flag is sticky and rises only together with a result.

The arithmetic itself can only be shown by the bench's scenarios. These are the pure zero-sequence path, the pure charging path, a long distorted three-phase run that exercises filter convergence, stimulus changes between strobes, and clamping in both directions.

// File: rtl/hc_pkg.sv
package hc_pkg;
  localparam int QS           = 15;     // Q15 constant scale
  localparam int K_THIRD      = 10923;  // 1/3
  localparam int K_INV_SQRT3  = 18919;  // 1/sqrt(3)
  localparam int K_HALF_SQRT3 = 28378;  // sqrt(3)/2
  localparam int NPH          = 3;
endpackage

// File: rtl/hc_clarke.sv
module hc_clarke
  import hc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IW     = 21,
  parameter int PW     = 49
) (
  input  logic signed [DATA_W-1:0] ia_i,
  input  logic signed [DATA_W-1:0] ib_i,
  input  logic signed [DATA_W-1:0] ic_i,
  output logic signed [IW-1:0]     al_o,
  output logic signed [IW-1:0]     be_o,
  output logic signed [IW-1:0]     z_o
);
  logic signed [PW-1:0] a_w, b_w, c_w;

  always_comb begin
    a_w  = PW'(ia_i);
    b_w  = PW'(ib_i);
    c_w  = PW'(ic_i);
    al_o = IW'(((a_w + a_w - b_w - c_w) * PW'(K_THIRD)) >>> QS);
    be_o = IW'(((b_w - c_w) * PW'(K_INV_SQRT3)) >>> QS);
    z_o  = IW'(((a_w + b_w + c_w) * PW'(K_THIRD)) >>> QS);
  end
endmodule

// File: rtl/hc_stf.sv
module hc_stf
  import hc_pkg::*;
#(
  parameter int IW     = 21,
  parameter int FRAC_W = 8,
  parameter int PW     = 49,
  parameter int KT     = 66,
  parameter int WT     = 1029
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic signed [IW-1:0] al_i,
  input  logic signed [IW-1:0] be_i,
  output logic signed [IW-1:0] fal_o,
  output logic signed [IW-1:0] fbe_o
);
  localparam int SW = IW + FRAC_W;

  logic signed [SW-1:0] fa_q, fb_q, fa_d, fb_d;
  logic signed [PW-1:0] ea, eb;

  // both axes advance from the old state pair
  always_comb begin
    ea    = (PW'(al_i) <<< FRAC_W) - PW'(fa_q);
    eb    = (PW'(be_i) <<< FRAC_W) - PW'(fb_q);
    fa_d  = SW'(PW'(fa_q) + ((PW'(KT) * ea - PW'(WT) * PW'(fb_q)) >>> QS));
    fb_d  = SW'(PW'(fb_q) + ((PW'(KT) * eb + PW'(WT) * PW'(fa_q)) >>> QS));
    fal_o = IW'(PW'(fa_d) >>> FRAC_W);
    fbe_o = IW'(PW'(fb_d) >>> FRAC_W);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fa_q <= '0;
      fb_q <= '0;
    end else if (en_i) begin
      fa_q <= fa_d;
      fb_q <= fb_d;
    end
  end
endmodule

// File: rtl/hc_rotor.sv
module hc_rotor #(
  parameter int DATA_W = 16,
  parameter int SC_W   = 16,
  parameter int IW     = 21,
  parameter int PW     = 49
) (
  input  logic signed [IW-1:0]     ha_i,
  input  logic signed [IW-1:0]     hb_i,
  input  logic signed [IW-1:0]     al_i,
  input  logic signed [IW-1:0]     be_i,
  input  logic signed [SC_W-1:0]   sin_i,
  input  logic signed [SC_W-1:0]   cos_i,
  input  logic signed [DATA_W-1:0] chg_i,
  output logic signed [IW-1:0]     ra_o,
  output logic signed [IW-1:0]     rb_o
);
  localparam int SH = SC_W - 1;

  logic signed [PW-1:0] s_w, c_w, d_w, q_w, e_w;

  always_comb begin
    s_w  = PW'(sin_i);
    c_w  = PW'(cos_i);
    d_w  = PW'(IW'((PW'(ha_i) * s_w - PW'(hb_i) * c_w) >>> SH));
    q_w  = PW'(IW'((PW'(al_i) * c_w + PW'(be_i) * s_w) >>> SH));
    e_w  = PW'(IW'(d_w - PW'(chg_i)));
    ra_o = IW'((e_w * s_w + q_w * c_w) >>> SH);
    rb_o = IW'((q_w * s_w - e_w * c_w) >>> SH);
  end
endmodule

// File: rtl/hc_sat.sv
module hc_sat #(
  parameter int DATA_W = 16,
  parameter int PW     = 49,
  parameter int LIMIT  = 30000
) (
  input  logic signed [PW-1:0]     x_i,
  output logic signed [DATA_W-1:0] y_o,
  output logic                     clip_o
);
  localparam logic signed [PW-1:0] HI = PW'(LIMIT);
  localparam logic signed [PW-1:0] LO = -PW'(LIMIT);

  always_comb begin
    clip_o = 1'b1;
    if (x_i > HI)      y_o = DATA_W'(HI);
    else if (x_i < LO) y_o = DATA_W'(LO);
    else begin
      y_o    = DATA_W'(x_i);
      clip_o = 1'b0;
    end
  end
endmodule

// File: rtl/hc_ref_gen.sv
module hc_ref_gen
  import hc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SC_W   = 16,
  parameter int FRAC_W = 8,
  parameter int KT     = 66,
  parameter int WT     = 1029,
  parameter int LIMIT  = 30000
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] ia_i,
  input  logic signed [DATA_W-1:0] ib_i,
  input  logic signed [DATA_W-1:0] ic_i,
  input  logic signed [SC_W-1:0]   sin_i,
  input  logic signed [SC_W-1:0]   cos_i,
  input  logic signed [DATA_W-1:0] chg_i,
  input  logic signed [DATA_W-1:0] bal_i,
  output logic signed [DATA_W-1:0] ref_a_o,
  output logic signed [DATA_W-1:0] ref_b_o,
  output logic signed [DATA_W-1:0] ref_c_o,
  output logic                     valid_o,
  output logic                     ovf_o
);
  localparam int IW = DATA_W + 5;
  localparam int PW = IW + FRAC_W + SC_W + 4;

  logic signed [IW-1:0] al, be, z0, fal, fbe, ha, hb, ra, rb;
  logic signed [PW-1:0] zc, hh, ss;
  logic signed [PW-1:0]     pre [NPH];
  logic signed [DATA_W-1:0] sat [NPH];
  logic signed [DATA_W-1:0] ref_q [NPH];
  logic [NPH-1:0] clip;

  hc_clarke #(.DATA_W(DATA_W), .IW(IW), .PW(PW)) u_clarke (
    .ia_i(ia_i), .ib_i(ib_i), .ic_i(ic_i), .al_o(al), .be_o(be), .z_o(z0)
  );

  hc_stf #(.IW(IW), .FRAC_W(FRAC_W), .PW(PW), .KT(KT), .WT(WT)) u_stf (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(valid_i),
    .al_i(al), .be_i(be), .fal_o(fal), .fbe_o(fbe)
  );

  assign ha = al - fal;
  assign hb = be - fbe;

  hc_rotor #(.DATA_W(DATA_W), .SC_W(SC_W), .IW(IW), .PW(PW)) u_rot (
    .ha_i(ha), .hb_i(hb), .al_i(al), .be_i(be),
    .sin_i(sin_i), .cos_i(cos_i), .chg_i(chg_i), .ra_o(ra), .rb_o(rb)
  );

  always_comb begin
    zc     = PW'(z0) - PW'(bal_i);
    hh     = PW'(ra) >>> 1;
    ss     = (PW'(rb) * PW'(K_HALF_SQRT3)) >>> QS;
    pre[0] = PW'(ra) + zc;
    pre[1] = zc - hh + ss;
    pre[2] = zc - hh - ss;
  end

  for (genvar p = 0; p < NPH; p++) begin : g_sat
    hc_sat #(.DATA_W(DATA_W), .PW(PW), .LIMIT(LIMIT)) u_sat (
      .x_i(pre[p]), .y_o(sat[p]), .clip_o(clip[p])
    );
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      ref_q[p] <= '0;
      else if (valid_i) ref_q[p] <= sat[p];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      ovf_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i && |clip) ovf_o <= 1'b1;
    end
  end

  assign ref_a_o = ref_q[0];
  assign ref_b_o = ref_q[1];
  assign ref_c_o = ref_q[2];
endmodule

// File: rtl/hc_ref_gen_chk.sv
module hc_ref_gen_chk #(
  parameter int DATA_W = 16,
  parameter int LIMIT  = 30000
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     valid_i,
  input logic signed [DATA_W-1:0] ref_a_o,
  input logic signed [DATA_W-1:0] ref_b_o,
  input logic signed [DATA_W-1:0] ref_c_o,
  input logic                     valid_o,
  input logic                     ovf_o
);
  localparam logic signed [DATA_W-1:0] LIM = DATA_W'(LIMIT);

  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  // R2
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (valid_o == $past(valid_i)));

  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !valid_o) |-> ($stable(ref_a_o) && $stable(ref_b_o) && $stable(ref_c_o)));

  // R7
  range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_a_o <= LIM) && (ref_a_o >= -LIM) && (ref_b_o <= LIM) && (ref_b_o >= -LIM)
    && (ref_c_o <= LIM) && (ref_c_o >= -LIM));

  // R8
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(ovf_o)) |-> ovf_o);

  // R8
  ovf_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $rose(ovf_o)) |-> valid_o);
endmodule

bind hc_ref_gen hc_ref_gen_chk #(.DATA_W(DATA_W), .LIMIT(LIMIT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
  .ref_a_o(ref_a_o), .ref_b_o(ref_b_o), .ref_c_o(ref_c_o),
  .valid_o(valid_o), .ovf_o(ovf_o)
);

// File: tb/sim_hc_ref_gen.sv
`timescale 1ns/1ps
module sim_hc_ref_gen;
  localparam int DW = 16;
  localparam int LIM = 30000;
  localparam longint KTM = 66, WTM = 1029;

  logic clk = 1'b0, rst_n = 1'b0, vin = 1'b0;
  logic signed [DW-1:0] ia = '0, ib = '0, ic = '0, sn = '0, cs = '0, chg = '0, bal = '0;
  logic signed [DW-1:0] ra, rb, rc;
  logic vout, ovf;

  int errs = 0, checks = 0, cyc = 0;
  bit done = 0;
  longint fa_m = 0, fb_m = 0;
  bit ovf_m = 0;
  longint ex[3];

  always #2.5 clk = ~clk;

  hc_ref_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vin), .ia_i(ia), .ib_i(ib), .ic_i(ic),
    .sin_i(sn), .cos_i(cs), .chg_i(chg), .bal_i(bal),
    .ref_a_o(ra), .ref_b_o(rb), .ref_c_o(rc), .valid_o(vout), .ovf_o(ovf)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic longint clamp(input longint v);
    if (v > LIM)  begin ovf_m = 1; return LIM;  end
    if (v < -LIM) begin ovf_m = 1; return -LIM; end
    return v;
  endfunction

  // behavioural model of one sample
  task automatic model(input longint a, b, c, s, co, cg, bl);
    longint al, be, z, na, nb, h1, h2, d, q, e, r1, r2, zz, hf, t;
    al = ((2*a - b - c) * 10923) >>> 15;
    be = ((b - c) * 18919) >>> 15;
    z  = ((a + b + c) * 10923) >>> 15;
    na = fa_m + ((KTM * ((al <<< 8) - fa_m) - WTM * fb_m) >>> 15);
    nb = fb_m + ((KTM * ((be <<< 8) - fb_m) + WTM * fa_m) >>> 15);
    fa_m = na; fb_m = nb;
    h1 = al - (fa_m >>> 8);
    h2 = be - (fb_m >>> 8);
    d  = (h1 * s - h2 * co) >>> 15;
    q  = (al * co + be * s) >>> 15;
    e  = d - cg;
    r1 = (e * s + q * co) >>> 15;
    r2 = (q * s - e * co) >>> 15;
    zz = z - bl;
    hf = r1 >>> 1;
    t  = (r2 * 28378) >>> 15;
    ex[0] = clamp(r1 + zz);
    ex[1] = clamp(-hf + t + zz);
    ex[2] = clamp(-hf - t + zz);
  endtask

  task automatic strobe(input int a, b, c, s, co, cg, bl, input string req);
    @(negedge clk);
    ia = DW'(a); ib = DW'(b); ic = DW'(c); sn = DW'(s); cs = DW'(co);
    chg = DW'(cg); bal = DW'(bl); vin = 1'b1;
    model(a, b, c, s, co, cg, bl);
    @(negedge clk);
    vin = 1'b0;
    chk(vout == 1'b1, "R2 valid", longint'(vout), 1);
    chk(longint'(ra) == ex[0], {req, " ref_a"}, longint'(ra), ex[0]);
    chk(longint'(rb) == ex[1], {req, " ref_b"}, longint'(rb), ex[1]);
    chk(longint'(rc) == ex[2], {req, " ref_c"}, longint'(rc), ex[2]);
    chk(ovf == ovf_m, "R8 ovf", longint'(ovf), longint'(ovf_m));
  endtask

  task automatic do_reset();
    rst_n = 1'b0; vin = 1'b0;
    fa_m = 0; fb_m = 0; ovf_m = 0;
    repeat (3) @(negedge clk);
    // R1
    chk(ra == 0 && rb == 0 && rc == 0, "R1 refs", longint'(ra), 0);
    chk(vout == 0, "R1 valid", longint'(vout), 0);
    chk(ovf == 0, "R1 ovf", longint'(ovf), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      errs++; checks++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    longint hold[3];
    real th;
    do_reset();

    // R3: zero path alone, hand value (3000*10923)>>>15 = 1000, minus 200
    strobe(1000, 1000, 1000, 0, 0, 500, 200, "R3 zero");
    chk(ra == 800 && rb == 800 && rc == 800, "R3 hand", longint'(ra), 800);

    // R6: charging only, ra=-1000, h=-500 -> a=-1000, b=c=500
    strobe(0, 0, 0, 32767, 0, 1000, 0, "R6 charge");
    chk(ra == -1000 && rb == 500 && rc == 500, "R6 hand", longint'(rb), 500);

    // R4 R5 R6: distorted unbalanced load, angle-locked sin/cos
    for (int n = 0; n < 600; n++) begin
      int a, b, c;
      th = 6.283185307 * n / 64.0;
      a = int'(9000.0*$sin(th) + 2500.0*$sin(5.0*th) + 1500.0*$sin(3.0*th));
      b = int'(6000.0*$sin(th - 2.094395) + 2000.0*$sin(5.0*(th - 2.094395)));
      c = int'(7000.0*$sin(th + 2.094395) + 1200.0*$sin(7.0*(th + 2.094395)));
      strobe(a, b, c, int'(32767.0*$sin(th)), int'(32767.0*$cos(th)),
             (n % 7) * 40 - 120, (n % 5) * 30 - 60, "R4 R5 R6 run");
    end

    // R9: inputs move without strobe; outputs hold, valid low
    hold[0] = ra; hold[1] = rb; hold[2] = rc;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      ia = DW'(12345 * (k + 1)); ib = DW'(-7000); ic = DW'(4321 * k);
      sn = DW'(20000); cs = DW'(-15000); chg = DW'(900); bal = DW'(-300);
      @(negedge clk);
      chk(vout == 0, "R9 valid low", longint'(vout), 0);
      chk(longint'(ra) == hold[0] && longint'(rb) == hold[1] && longint'(rc) == hold[2],
          "R9 hold", longint'(ra), hold[0]);
    end
    // filter state untouched: next strobe still matches model
    strobe(3000, -1000, -2000, 23170, 23170, 50, 10, "R9 state");

    // R7 R8: clamp high then low, then sticky
    strobe(32000, 32000, 32000, 0, 0, 0, -10000, "R7 high");
    chk(ra == LIM && rb == LIM && rc == LIM, "R7 high hand", longint'(ra), LIM);
    chk(ovf == 1, "R8 set", longint'(ovf), 1);
    strobe(-32000, -32000, -32000, 0, 0, 0, 10000, "R7 low");
    chk(ra == -LIM && rc == -LIM, "R7 low hand", longint'(ra), -LIM);
    strobe(100, 200, 300, 0, 32767, 0, 0, "R8 sticky");
    chk(ovf == 1, "R8 sticky hand", longint'(ovf), 1);

    // R1: reset clears flag, outputs, filter
    do_reset();
    strobe(5000, -2500, -2500, 0, 32767, 0, 0, "R1 after reset");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule